// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps the time of day and the calendar date: seconds, minutes, hours, weekday, day of month, month and year. It steps forward by one second on each cycle in which the one-second strobe is high and the run bit is set. The carries ripple from seconds up to the year. Month lengths follow the Gregorian calendar, and so do leap years, which are tested on the full year (a base year plus the stored year count).

Software reaches the block through a plain port made of an address, a write strobe, write data and combinational read data. Every field is presented in packed BCD. On a write the value is decoded to binary, and on a read it is encoded back to BCD. The month is held internally as 0 to 11 but is shown as 1 to 12. The year is a three-digit BCD value that spans two bytes. A time or date write is taken only while the run bit is set. If a write and a second strobe arrive in the same cycle, the write wins and that second is dropped.

Top module: `caltime_counter`

## Requirements
- R1: When the strobe is accepted, seconds step by one. Seconds at 59 or above wrap to 0 and carry into minutes. Minutes at 59 or above wrap to 0 and carry into hours. Hours at 23 or above wrap to 0 and produce a day carry.
- R2: Each day carry advances the weekday (address 4) modulo 7, from 6 back to 0. The weekday does not depend on the date.
- R3: On a day carry, the day of month (address 5) increments. Once it would pass the length of the current month (31,28,31,30,31,30,31,31,30,31,30,31 from January to December), it returns to 1 and the month advances.
- R4: February has 29 days when the full year (base 1900 plus the stored year count) is divisible by 4 and is either not divisible by 100 or divisible by 400. Otherwise it has 28 days.
- R5: When December rolls over, the month becomes January and the year count increments. The year count wraps from 999 to 0.
- R6: The month (address 6) reads as BCD 0x01 to 0x12. A write decodes the BCD byte and subtracts 1 to give the internal month, which runs from 0 (January) to 11 (December).
- R7: The year (address 7) reads with the tens and units BCD digits in bits [7:0] and the hundreds digit in bits [11:8], taken from the count modulo 1000. A write takes the decoded value of bits [7:0] plus 100 times bits [11:8].
- R8: A time or date write while the run bit is clear is ignored. The strobe is also ignored while the run bit is clear, so every field holds its value.
- R9: Seconds (1), minutes (2), hours (3), weekday (4) and day of month (5) are written and read as two-digit packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0].
- R10: A day of month loaded as 0 becomes 1 on the next accepted strobe.
- R11: In a cycle that carries both an accepted field write and the strobe, the write is applied and no field advances.
- R12: Reset sets the date to day 1, month 1 (January), year count 100 (the year 2000), time 00:00:00, weekday 0 and run bit 0.
- R13: Address 0 is the control register, with the run bit in bit 0. A write to it is always accepted, and a read returns the run bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe that marks one elapsed second |
| bus_addr | input | ADDR_W (3) | Register address: 0 control, 1 to 7 time and date fields |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | DATA_W (12) | Write data |
| bus_rdata | output | DATA_W (12) | Combinational read data for the addressed register |

## Verification
The carry chain is exercised from several starting points: a mid-month 23:59:59 that also wraps the weekday from 6 to 0, the last day of 30-day and 31-day months, the end of February in the years 2000, 2024, 1900 and 2100, and 31 December 2099. Together these separate a wrong month table from a wrong leap rule, and they show whether the 400-year exception or the 100-year exception is being applied. The BCD port is checked with values whose tens and units digits differ, with the one-based month and with a year whose hundreds nibble is above 9. These checks show whether the digits are swapped, whether the month offset is missing, and whether the year fields are misplaced. Three further cases are covered by their own tests: the disabled state, a day of month loaded as 0, and a write that coincides with the strobe.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

   typedef logic [7:0] fld8_t;

   // field indices; the register address of field k is k+1
   localparam int F_SEC    = 0;
   localparam int F_MIN    = 1;
   localparam int F_HOUR   = 2;
   localparam int F_WDAY   = 3;
   localparam int F_MDAY   = 4;
   localparam int F_MON    = 5;
   localparam int F_YEAR   = 6;
   localparam int N_FIELDS = 7;
   localparam int N_CLOCK  = 3;   // seconds, minutes, hours
   localparam int CTRL_ADDR = 0;
   localparam int WEEK_LEN  = 7;
   localparam int YEAR_LEN  = 12;

   function automatic int clock_limit(input int idx);
      case (idx)
         0, 1:    return 60;
         default: return 24;
      endcase
   endfunction

   function automatic fld8_t bin_to_bcd(input fld8_t v);
      fld8_t tens;
      fld8_t ones;
      tens = v / 8'd10;
      ones = v % 8'd10;
      return {tens[3:0], ones[3:0]};
   endfunction

   function automatic fld8_t bcd_to_bin(input fld8_t b);
      return ({4'b0000, b[7:4]} * 8'd10) + {4'b0000, b[3:0]};
   endfunction

   // month index is zero-based
   function automatic fld8_t month_days(input fld8_t mon0, input logic leap);
      case (mon0)
         8'd1:                 return leap ? 8'd29 : 8'd28;
         8'd3, 8'd5, 8'd8, 8'd10: return 8'd30;
         default:              return 8'd31;
      endcase
   endfunction

endpackage

// File: rtl/caltime_wrapctr.sv
module caltime_wrapctr #(
   parameter int W       = 8,
   parameter int LIMIT   = 60,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] val,
   output logic         carry
);

   logic [W:0] step;
   logic       at_top;

   assign step   = {1'b0, val} + (W+1)'(1);
   assign at_top = (step >= (W+1)'(LIMIT));
   assign carry  = inc & at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val <= W'(RST_VAL);
      end else if (load) begin
         val <= load_val;
      end else if (inc) begin
         val <= at_top ? '0 : step[W-1:0];
      end
   end

endmodule

// File: rtl/caltime_date.sv
module caltime_date
   import caltime_pkg::*;
#(
   parameter int YW        = 11,
   parameter int YEAR_BASE = 1900,
   parameter int YEAR_SPAN = 1000,
   parameter int RST_YEAR  = 100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          day_inc,
   input  logic          ld_wday,
   input  logic          ld_mday,
   input  logic          ld_mon,
   input  logic          ld_year,
   input  fld8_t         fld_in,
   input  fld8_t         mon_in,
   input  logic [YW-1:0] year_in,
   output fld8_t         wday_q,
   output fld8_t         mday_q,
   output fld8_t         mon_q,
   output logic [YW-1:0] year_q
);

   logic [15:0] full_year;
   logic        leap;
   fld8_t       mlen;
   logic [8:0]  mday_step;
   logic [8:0]  mon_step;
   logic [8:0]  wday_step;
   logic [YW:0] year_step;
   logic        month_carry;
   logic        year_carry;

   assign full_year = 16'(YEAR_BASE) + 16'(year_q);
   assign leap = ((full_year % 16'd4) == 16'd0) &&
                 (((full_year % 16'd100) != 16'd0) || ((full_year % 16'd400) == 16'd0));
   assign mlen = month_days(mon_q, leap);

   assign mday_step   = {1'b0, mday_q} + 9'd1;
   assign mon_step    = {1'b0, mon_q} + 9'd1;
   assign wday_step   = {1'b0, wday_q} + 9'd1;
   assign year_step   = {1'b0, year_q} + (YW+1)'(1);
   assign month_carry = day_inc && (mday_q != 8'd0) && (mday_step > {1'b0, mlen});
   assign year_carry  = month_carry && (mon_step >= 9'(YEAR_LEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wday_q <= 8'd0;
      end else if (ld_wday) begin
         wday_q <= fld_in;
      end else if (day_inc) begin
         wday_q <= (wday_step >= 9'(WEEK_LEN)) ? 8'd0 : wday_step[7:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mday_q <= 8'd1;
      end else if (ld_mday) begin
         mday_q <= fld_in;
      end else if (day_inc) begin
         mday_q <= month_carry ? 8'd1 : mday_step[7:0];
      end else if (adv && (mday_q == 8'd0)) begin
         mday_q <= 8'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mon_q <= 8'd0;
      end else if (ld_mon) begin
         mon_q <= mon_in;
      end else if (month_carry) begin
         mon_q <= year_carry ? 8'd0 : mon_step[7:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         year_q <= YW'(RST_YEAR);
      end else if (ld_year) begin
         year_q <= year_in;
      end else if (year_carry) begin
         year_q <= (year_step >= (YW+1)'(YEAR_SPAN)) ? '0 : year_step[YW-1:0];
      end
   end

endmodule

// File: rtl/caltime_regmap.sv
module caltime_regmap
   import caltime_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 12,
   parameter int YW     = 11
) (
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic                run_q,
   input  fld8_t               sec_q,
   input  fld8_t               min_q,
   input  fld8_t               hour_q,
   input  fld8_t               wday_q,
   input  fld8_t               mday_q,
   input  fld8_t               mon_q,
   input  logic [YW-1:0]       year_q,
   output logic                ctrl_wr,
   output logic [N_FIELDS-1:0] field_ld,
   output fld8_t               fld_val,
   output fld8_t               mon_val,
   output logic [YW-1:0]       year_val,
   output logic [DATA_W-1:0]   bus_rdata
);

   logic [YW-1:0] year_mod;
   fld8_t         year_lo;
   fld8_t         year_hi;
   fld8_t         year_lo_bcd;
   fld8_t         year_hi_bcd;

   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

   for (genvar k = 0; k < N_FIELDS; k++) begin : g_ld
      assign field_ld[k] = bus_wr && run_q && (bus_addr == ADDR_W'(k + 1));
   end

   assign fld_val  = bcd_to_bin(bus_wdata[7:0]);
   assign mon_val  = fld_val - 8'd1;
   assign year_val = YW'(fld_val) + (YW'(bus_wdata[11:8]) * YW'(100));

   assign year_mod    = year_q % YW'(1000);
   assign year_lo     = 8'(year_mod % YW'(100));
   assign year_hi     = 8'(year_mod / YW'(100));
   assign year_lo_bcd = bin_to_bcd(year_lo);
   assign year_hi_bcd = bin_to_bcd(year_hi);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(CTRL_ADDR):  bus_rdata = DATA_W'(run_q);
         ADDR_W'(F_SEC + 1):  bus_rdata = DATA_W'(bin_to_bcd(sec_q));
         ADDR_W'(F_MIN + 1):  bus_rdata = DATA_W'(bin_to_bcd(min_q));
         ADDR_W'(F_HOUR + 1): bus_rdata = DATA_W'(bin_to_bcd(hour_q));
         ADDR_W'(F_WDAY + 1): bus_rdata = DATA_W'(bin_to_bcd(wday_q));
         ADDR_W'(F_MDAY + 1): bus_rdata = DATA_W'(bin_to_bcd(mday_q));
         ADDR_W'(F_MON + 1):  bus_rdata = DATA_W'(bin_to_bcd(mon_q + 8'd1));
         ADDR_W'(F_YEAR + 1): bus_rdata = DATA_W'({year_hi_bcd[3:0], year_lo_bcd});
         default:             bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/caltime_counter.sv
module caltime_counter
   import caltime_pkg::*;
#(
   parameter int ADDR_W     = 3,
   parameter int DATA_W     = 12,
   parameter int YEAR_W     = 11,
   parameter int YEAR_BASE  = 1900,
   parameter int YEAR_SPAN  = 1000,
   parameter int EPOCH_YEAR = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("caltime_counter: ADDR_W must cover eight registers");
   end
   if (DATA_W < 12) begin : g_bad_data
      $error("caltime_counter: DATA_W must hold a three-digit BCD year");
   end
   if ((YEAR_W < 11) || (YEAR_W > 16)) begin : g_bad_year_w
      $error("caltime_counter: YEAR_W must lie in 11..16");
   end
   if ((YEAR_SPAN > 1000) || (EPOCH_YEAR >= YEAR_SPAN)) begin : g_bad_span
      $error("caltime_counter: year span or epoch out of range");
   end

   logic                run_q;
   logic                ctrl_wr;
   logic [N_FIELDS-1:0] field_ld;
   fld8_t               fld_val;
   fld8_t               mon_val;
   logic [YEAR_W-1:0]   year_val;
   logic                adv;
   logic [N_CLOCK-1:0]  inc;
   logic [N_CLOCK-1:0]  carry;
   fld8_t               hms_q [N_CLOCK];
   fld8_t               wday_q;
   fld8_t               mday_q;
   fld8_t               mon_q;
   logic [YEAR_W-1:0]   year_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (ctrl_wr) begin
         run_q <= bus_wdata[0];
      end
   end

   // an accepted field write suppresses this cycle's second
   assign adv = sec_tick && run_q && !(|field_ld);

   for (genvar i = 0; i < N_CLOCK; i++) begin : g_clk
      if (i == 0) begin : g_head
         assign inc[i] = adv;
      end else begin : g_chain
         assign inc[i] = carry[i-1];
      end
      caltime_wrapctr #(
         .W      (8),
         .LIMIT  (clock_limit(i)),
         .RST_VAL(0)
      ) u_ctr (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc     (inc[i]),
         .load    (field_ld[F_SEC + i]),
         .load_val(fld_val),
         .val     (hms_q[i]),
         .carry   (carry[i])
      );
   end

   caltime_date #(
      .YW       (YEAR_W),
      .YEAR_BASE(YEAR_BASE),
      .YEAR_SPAN(YEAR_SPAN),
      .RST_YEAR (EPOCH_YEAR)
   ) u_date (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .day_inc(carry[N_CLOCK-1]),
      .ld_wday(field_ld[F_WDAY]),
      .ld_mday(field_ld[F_MDAY]),
      .ld_mon (field_ld[F_MON]),
      .ld_year(field_ld[F_YEAR]),
      .fld_in (fld_val),
      .mon_in (mon_val),
      .year_in(year_val),
      .wday_q (wday_q),
      .mday_q (mday_q),
      .mon_q  (mon_q),
      .year_q (year_q)
   );

   caltime_regmap #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .YW    (YEAR_W)
   ) u_regs (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .run_q    (run_q),
      .sec_q    (hms_q[F_SEC]),
      .min_q    (hms_q[F_MIN]),
      .hour_q   (hms_q[F_HOUR]),
      .wday_q   (wday_q),
      .mday_q   (mday_q),
      .mon_q    (mon_q),
      .year_q   (year_q),
      .ctrl_wr  (ctrl_wr),
      .field_ld (field_ld),
      .fld_val  (fld_val),
      .mon_val  (mon_val),
      .year_val (year_val),
      .bus_rdata(bus_rdata)
   );

endmodule

// File: rtl/caltime_counter_chk.sv
module caltime_counter_chk #(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sec_tick,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              run_q,
   input logic [7:0]        sec_q,
   input logic [7:0]        min_q,
   input logic [7:0]        hour_q,
   input logic [7:0]        wday_q,
   input logic [7:0]        mday_q
);

   AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) &&
                  $stable(wday_q) && $stable(mday_q)));                      // R8

   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && sec_tick && !bus_wr && (sec_q >= 8'd59)) |=> (sec_q == 8'd0)); // R1

   AST_MIN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && sec_tick && !bus_wr && (sec_q >= 8'd59) && (min_q < 8'd58))
      |=> (min_q == $past(min_q) + 8'd1));                                   // R1

   AST_WDAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && sec_tick && !bus_wr && (sec_q >= 8'd59) && (min_q >= 8'd59) &&
       (hour_q >= 8'd23) && (wday_q < 8'd5))
      |=> (wday_q == $past(wday_q) + 8'd1));                                 // R2

   AST_DAY_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && sec_tick && !bus_wr) |=> (mday_q != 8'd0));                  // R10

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && sec_tick && bus_wr && (bus_addr == ADDR_W'(2))) |=> $stable(sec_q)); // R11

endmodule

bind caltime_counter caltime_counter_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sec_tick(sec_tick),
   .bus_wr  (bus_wr),
   .bus_addr(bus_addr),
   .run_q   (run_q),
   .sec_q   (hms_q[0]),
   .min_q   (hms_q[1]),
   .hour_q  (hms_q[2]),
   .wday_q  (wday_q),
   .mday_q  (mday_q)
);

// File: tb/caltime_counter_test.sv
module caltime_counter_test;

   localparam int AW = 3;
   localparam int DW = 12;
   localparam logic [2:0] A_CTRL = 3'd0, A_SEC = 3'd1, A_MIN = 3'd2, A_HOUR = 3'd3,
                          A_WDAY = 3'd4, A_MDAY = 3'd5, A_MON = 3'd6, A_YEAR = 3'd7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sec_tick = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   caltime_counter uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   task automatic chk(input string req, input string what, input logic [DW-1:0] got,
                      input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sec_tick = 1'b1;
         @(negedge clk);
         sec_tick = 1'b0;
      end
   endtask

   task automatic expect_reg(input string req, input string what, input logic [AW-1:0] a,
                             input logic [DW-1:0] exp);
      logic [DW-1:0] v;
      rd(a, v);
      chk(req, what, v, exp);
   endtask

   task automatic set_all(input logic [DW-1:0] y, input logic [DW-1:0] mo,
                          input logic [DW-1:0] d, input logic [DW-1:0] h,
                          input logic [DW-1:0] mi, input logic [DW-1:0] s);
      wr(A_YEAR, y); wr(A_MON, mo); wr(A_MDAY, d);
      wr(A_HOUR, h); wr(A_MIN, mi); wr(A_SEC, s);
   endtask

   task automatic t_reset;
      expect_reg("R12", "ctrl", A_CTRL, 12'h000);
      expect_reg("R12", "sec", A_SEC, 12'h000);
      expect_reg("R12", "min", A_MIN, 12'h000);
      expect_reg("R12", "hour", A_HOUR, 12'h000);
      expect_reg("R12", "wday", A_WDAY, 12'h000);
      expect_reg("R12", "mday", A_MDAY, 12'h001);
      expect_reg("R12", "month", A_MON, 12'h001);
      expect_reg("R12", "year", A_YEAR, 12'h100);
   endtask

   task automatic t_ignored_when_off;
      wr(A_SEC, 12'h030);
      expect_reg("R8", "sec write while off", A_SEC, 12'h000);
      tick(2);
      expect_reg("R8", "sec after strobe while off", A_SEC, 12'h000);
      wr(A_CTRL, 12'h001);
      expect_reg("R13", "ctrl run bit", A_CTRL, 12'h001);
   endtask

   task automatic t_bcd_fields;
      wr(A_SEC, 12'h045);  expect_reg("R9", "sec bcd", A_SEC, 12'h045);
      wr(A_MIN, 12'h009);  expect_reg("R9", "min bcd", A_MIN, 12'h009);
      wr(A_HOUR, 12'h017); expect_reg("R9", "hour bcd", A_HOUR, 12'h017);
      wr(A_WDAY, 12'h003); expect_reg("R9", "wday bcd", A_WDAY, 12'h003);
      wr(A_MDAY, 12'h027); expect_reg("R9", "mday bcd", A_MDAY, 12'h027);
      tick(1);
      expect_reg("R1", "sec step", A_SEC, 12'h046);
   endtask

   task automatic t_clock_carry;
      set_all(12'h123, 12'h003, 12'h015, 12'h023, 12'h059, 12'h058);
      wr(A_WDAY, 12'h006);
      tick(1);
      expect_reg("R1", "sec to 59", A_SEC, 12'h059);
      tick(1);
      expect_reg("R1", "sec wrap", A_SEC, 12'h000);
      expect_reg("R1", "min wrap", A_MIN, 12'h000);
      expect_reg("R1", "hour wrap", A_HOUR, 12'h000);
      expect_reg("R2", "wday 6 to 0", A_WDAY, 12'h000);
      expect_reg("R3", "mday mid month", A_MDAY, 12'h016);
      expect_reg("R3", "month kept", A_MON, 12'h003);
   endtask

   task automatic t_month_ends;
      set_all(12'h123, 12'h004, 12'h030, 12'h023, 12'h059, 12'h059);
      tick(1);
      expect_reg("R3", "april end day", A_MDAY, 12'h001);
      expect_reg("R3", "april end month", A_MON, 12'h005);
      set_all(12'h123, 12'h001, 12'h031, 12'h023, 12'h059, 12'h059);
      tick(1);
      expect_reg("R3", "january end day", A_MDAY, 12'h001);
      expect_reg("R3", "january end month", A_MON, 12'h002);
   endtask

   task automatic t_leap_years;
      set_all(12'h100, 12'h002, 12'h028, 12'h023, 12'h059, 12'h059);
      tick(1);
      expect_reg("R4", "2000 feb 29", A_MDAY, 12'h029);
      wr(A_HOUR, 12'h023); wr(A_MIN, 12'h059); wr(A_SEC, 12'h059);
      tick(1);
      expect_reg("R4", "2000 mar 1 month", A_MON, 12'h003);
      set_all(12'h124, 12'h002, 12'h028, 12'h023, 12'h059, 12'h059);
      tick(1);
      expect_reg("R4", "2024 feb 29", A_MDAY, 12'h029);
      set_all(12'h000, 12'h002, 12'h028, 12'h023, 12'h059, 12'h059);
      tick(1);
      expect_reg("R4", "1900 mar 1 day", A_MDAY, 12'h001);
      expect_reg("R4", "1900 mar 1 month", A_MON, 12'h003);
   endtask

   task automatic t_year_roll;
      set_all(12'h199, 12'h012, 12'h031, 12'h023, 12'h059, 12'h059);
      expect_reg("R6", "december reads 12", A_MON, 12'h012);
      tick(1);
      expect_reg("R5", "january after december", A_MON, 12'h001);
      expect_reg("R5", "day 1 new year", A_MDAY, 12'h001);
      expect_reg("R5", "year 2099 to 2100", A_YEAR, 12'h200);
      wr(A_MON, 12'h002); wr(A_MDAY, 12'h028);
      wr(A_HOUR, 12'h023); wr(A_MIN, 12'h059); wr(A_SEC, 12'h059);
      tick(1);
      expect_reg("R4", "2100 no leap day", A_MDAY, 12'h001);
      set_all(12'h999, 12'h012, 12'h031, 12'h023, 12'h059, 12'h059);
      tick(1);
      expect_reg("R5", "year count wraps", A_YEAR, 12'h000);
   endtask

   task automatic t_month_base;
      set_all(12'h123, 12'h009, 12'h030, 12'h023, 12'h059, 12'h059);
      expect_reg("R6", "september reads 9", A_MON, 12'h009);
      tick(1);
      expect_reg("R6", "september has 30 days", A_MDAY, 12'h001);
      expect_reg("R6", "october reads 10", A_MON, 12'h010);
   endtask

   task automatic t_year_layout;
      wr(A_YEAR, 12'h345);
      expect_reg("R7", "year 345", A_YEAR, 12'h345);
      wr(A_YEAR, 12'hF99);
      expect_reg("R7", "hundreds nibble 15", A_YEAR, 12'h599);
   endtask

   task automatic t_day_floor;
      wr(A_SEC, 12'h010);
      wr(A_MDAY, 12'h000);
      expect_reg("R10", "mday loaded zero", A_MDAY, 12'h000);
      tick(1);
      expect_reg("R10", "mday corrected", A_MDAY, 12'h001);
      expect_reg("R10", "sec advanced", A_SEC, 12'h011);
   endtask

   task automatic t_write_wins;
      wr(A_SEC, 12'h010);
      wr(A_MIN, 12'h005);
      @(negedge clk);
      sec_tick = 1'b1; bus_wr = 1'b1; bus_addr = A_MIN; bus_wdata = 12'h022;
      @(negedge clk);
      sec_tick = 1'b0; bus_wr = 1'b0;
      expect_reg("R11", "sec held on write", A_SEC, 12'h010);
      expect_reg("R11", "min written", A_MIN, 12'h022);
   endtask

   task automatic t_stop;
      wr(A_CTRL, 12'h000);
      expect_reg("R13", "ctrl cleared", A_CTRL, 12'h000);
      tick(3);
      expect_reg("R8", "sec frozen", A_SEC, 12'h010);
      wr(A_MIN, 12'h040);
      expect_reg("R8", "min write ignored", A_MIN, 12'h022);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ignored_when_off();
      t_bcd_fields();
      t_clock_carry();
      t_month_ends();
      t_leap_years();
      t_year_roll();
      t_month_base();
      t_year_layout();
      t_day_floor();
      t_write_wins();
      t_stop();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule